// File: doc/BRIEF.md
# Serial Converter Output Frame Generator

This block is the device-side digital logic of a 10-bit successive-approximation converter that has a three-wire serial output. An active-low select line wakes the block and starts a conversion. The serial clock level seen at that moment sets how the conversion is timed:

- **Internal mode** (clock high). A conversion timer runs on the free-running system clock. When it expires, the result is taken from the result port and the data line rises as an end-of-conversion flag.
- **External mode** (clock low). The first falling serial-clock edge is the sampling instant.

The captured result then goes out as a 16-bit frame, one bit per falling serial-clock edge. The select line and serial clock are asynchronous to the system clock. Each passes through a two-flop synchronizer before any edge is detected. Raising the select line at any time shuts the block down and releases the data line.

Top module: `adc_frame_tx`

## Requirements
- R1: On a falling edge of `csN`, the `sclk` level picks the mode. High starts an internal conversion, and `sdo` rises exactly `CONV_CYCLES` system clocks after the block sees the edge. Low selects external mode, where `sdo` stays 0 until the first `sclk` falling edge.
- R2: The frame is 16 bits, sent most significant first: 1, 1, 1, the channel bit, the ten code bits from bit 9 down to bit 0, then sub-bit 1, then sub-bit 0.
- R3: In internal mode, `sdo` is 0 while the conversion runs. It becomes 1 (the first of the three ones) once the timer expires. Falling `sclk` edges during the conversion are ignored.
- R4: After the frame starts, each falling `sclk` edge moves `sdo` to the next frame bit. In external mode, the first falling edge presents the first frame bit.
- R5: Falling `sclk` edges after the last sub-bit, with `csN` still low, give `sdo` = 0.
- R6: While `csN` is high, `sdoEn` = 0 and `sdo` = 0, and `sclk` activity has no effect. While `csN` is low, `sdoEn` = 1.
- R7: Raising `csN` during a conversion or a frame aborts it. The next falling edge starts a fresh conversion with fresh data.
- R8: The channel bit carries `resChan`: 0 for channel 0, 1 for channel 1.
- R9: The result is captured once, at timer expiry (internal mode) or at the first `sclk` fall (external mode). It is held for the whole frame, even if the result port changes later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select / shutdown, asynchronous |
| sclk | input | 1 | Serial readout clock, asynchronous |
| resCode | input | DATA_W | Converter result code |
| resChan | input | 1 | Channel of the result |
| resSub | input | SUB_W | Sub-LSB bits, S1 in the upper position |
| sdo | output | 1 | Serial data |
| sdoEn | output | 1 | Drive enable; 0 models high impedance |

## Verification
The bench builds the block with `CONV_CYCLES` = 24 and two synchronizer stages. This gives a conversion window long enough to place several ignored `sclk` falls inside it, and to abort it partway. It still lets the exact expiry cycle be checked against a latency that can be counted (three clocks of edge detection, then 24).

A serial clock of eight system clocks per period keeps each bit settled before the host-side sample point. This makes it possible to check the full frame, the trailing zeros and a mid-frame abort in both modes.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_SHIFT = 2'd3
  } ctrlState_t;

  typedef struct packed {
    logic loadResult;
    logic advance;
    logic drive;
    logic showBits;
  } frameStrobe_t;

endpackage

// File: rtl/adc_frame_sync.sv
module adc_frame_sync #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RESET_VAL;
          else       chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[i] <= RESET_VAL;
          else       chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int CONV_CYCLES = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csLvl,
  input  logic         sclkLvl,
  output frameStrobe_t strobe
);
  localparam int TW = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(CONV_CYCLES - 1);

  ctrlState_t state;
  logic [TW-1:0] timer;
  logic csLast, sclkLast;
  logic csFall, sclkFall;

  assign csFall   = csLast & ~csLvl;
  assign sclkFall = sclkLast & ~sclkLvl;

  always_comb begin
    strobe = '0;
    strobe.drive      = (state != ST_IDLE);
    strobe.showBits   = (state == ST_SHIFT);
    strobe.loadResult = !csLvl &&
                        (((state == ST_CONV) && (timer == LAST)) ||
                         ((state == ST_WAIT) && sclkFall));
    strobe.advance    = !csLvl && (state == ST_SHIFT) && sclkFall;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csLast   <= 1'b1;
      sclkLast <= 1'b0;
    end else begin
      csLast   <= csLvl;
      sclkLast <= sclkLvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else if (csLvl) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (csFall) begin
            timer <= '0;
            state <= sclkLvl ? ST_CONV : ST_WAIT;
          end
        end
        ST_CONV: begin
          if (timer == LAST) state <= ST_SHIFT;
          else               timer <= timer + 1'b1;
        end
        ST_WAIT:  if (sclkFall) state <= ST_SHIFT;
        default:  state <= ST_SHIFT;
      endcase
    end
  end

  // R6: a deselected block is idle one clock later
  assert_idle_on_deselect_R6: assert property (@(posedge clk) disable iff (!rstN)
    csLvl |=> (state == ST_IDLE));

  // R1: clock level at select fall picks the branch
  assert_mode_internal_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && csFall && sclkLvl) |=> (state == ST_CONV));
  assert_mode_external_R1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && csFall && !sclkLvl) |=> (state == ST_WAIT));

  // R3: conversion timer never runs past its limit
  assert_timer_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV) |-> (timer <= LAST));

  // R9: capture and shift never coincide
  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadResult, strobe.advance}));
endmodule

// File: rtl/adc_frame_dp.sv
module adc_frame_dp
  import adc_frame_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int SUB_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStrobe_t      strobe,
  input  logic [DATA_W-1:0] code,
  input  logic              chan,
  input  logic [SUB_W-1:0]  sub,
  output logic              sdo,
  output logic              sdoEn
);
  localparam int LEAD_W  = 3;
  localparam int FRAME_W = LEAD_W + 1 + DATA_W + SUB_W;

  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  frame <= '0;
    else if (strobe.loadResult) frame <= {{LEAD_W{1'b1}}, chan, code, sub};
    else if (strobe.advance)    frame <= {frame[FRAME_W-2:0], 1'b0};
  end

  assign sdo   = strobe.showBits & frame[FRAME_W-1];
  assign sdoEn = strobe.drive;

  // R4: each advance brings up the next bit
  assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (frame[FRAME_W-1] == $past(frame[FRAME_W-2])));

  // R9: captured frame is held between strobes
  assert_frame_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadResult && !strobe.advance) |=> $stable(frame));

  // R2: a fresh capture always leads with a one
  assert_lead_one_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadResult |=> frame[FRAME_W-1]);
endmodule

// File: rtl/adc_frame_tx.sv
module adc_frame_tx
  import adc_frame_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SUB_W       = 2,
  parameter int CONV_CYCLES = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic [DATA_W-1:0] resCode,
  input  logic              resChan,
  input  logic [SUB_W-1:0]  resSub,
  output logic              sdo,
  output logic              sdoEn
);
  logic csLvl, sclkLvl;
  frameStrobe_t strobe;

  adc_frame_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) csSync_i (
    .clk(clk), .rstN(rstN), .din(csN), .dout(csLvl));

  adc_frame_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) sclkSync_i (
    .clk(clk), .rstN(rstN), .din(sclk), .dout(sclkLvl));

  adc_frame_ctrl #(.CONV_CYCLES(CONV_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csLvl(csLvl), .sclkLvl(sclkLvl), .strobe(strobe));

  adc_frame_dp #(.DATA_W(DATA_W), .SUB_W(SUB_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .code(resCode), .chan(resChan),
    .sub(resSub), .sdo(sdo), .sdoEn(sdoEn));

  // R6: released line carries no data
  assert_quiet_when_released_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sdoEn |-> !sdo);
endmodule

// File: tb/adc_frame_tx_tb_top.sv
module adc_frame_tx_tb_top;
  localparam int CONV = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sclk = 1'b0;
  logic [9:0] resCode = '0;
  logic resChan = 1'b0;
  logic [1:0] resSub = '0;
  logic sdo, sdoEn;

  int errs = 0;
  int checks = 0;
  int wdog = 0;

  always #10 clk = ~clk;

  adc_frame_tx #(.DATA_W(10), .SUB_W(2), .CONV_CYCLES(CONV), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .resCode(resCode),
    .resChan(resChan), .resSub(resSub), .sdo(sdo), .sdoEn(sdoEn));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: delayed input history, phase, frame held as integer
  bit csH[3];
  bit skH[3];
  int phase, cnt, bitIdx;
  logic [15:0] mFrame;
  logic expEn, expSdo;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 3; i++) begin csH[i] = 1'b1; skH[i] = 1'b0; end
      phase = 0; cnt = 0; bitIdx = 16; mFrame = '0;
    end else begin
      bit cFall, sFall;
      cFall = csH[2] && !csH[1];
      sFall = skH[2] && !skH[1];
      if (csH[1]) phase = 0;
      else begin
        case (phase)
          0: if (cFall) begin phase = skH[1] ? 1 : 2; cnt = 0; end
          1: if (cnt == CONV - 1) begin
               mFrame = {3'b111, resChan, resCode, resSub}; bitIdx = 0; phase = 3;
             end else cnt++;
          2: if (sFall) begin
               mFrame = {3'b111, resChan, resCode, resSub}; bitIdx = 0; phase = 3;
             end
          default: if (sFall && bitIdx < 16) bitIdx++;
        endcase
      end
      csH[2] = csH[1]; csH[1] = csH[0]; csH[0] = csN;
      skH[2] = skH[1]; skH[1] = skH[0]; skH[0] = sclk;
    end
    expEn  = (phase != 0);
    expSdo = (phase == 3 && bitIdx < 16) ? mFrame[15 - bitIdx] : 1'b0;
  end

  always @(negedge clk) begin
    if (rstN) begin
      string tag;
      tag = (phase == 1) ? "R3" : (phase == 3) ? "R2" : (phase == 0) ? "R6" : "R4";
      check({sdoEn, sdo} === {expEn, expSdo}, tag, {sdoEn, sdo}, {expEn, expSdo});
    end
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] frameOf(input logic ch, input logic [9:0] c, input logic [1:0] s);
    return {3'b111, ch, c, s};
  endfunction

  task automatic pulse();
    sclk = 1'b1; hold(4); sclk = 1'b0; hold(4);
  endtask

  // external readout; optionally disturbs the result port after sampling
  task automatic readExt(output logic [15:0] f, input bit scramble);
    pulse();
    if (scramble) begin resCode = ~resCode; resChan = ~resChan; resSub = ~resSub; end
    for (int i = 0; i < 16; i++) begin
      f[15 - i] = sdo;
      pulse();
    end
  endtask

  // internal readout; sclk is high and the end-of-conversion bit is showing
  task automatic readInt(output logic [15:0] f, input bit scramble);
    if (scramble) begin resCode = ~resCode; resChan = ~resChan; resSub = ~resSub; end
    f[15] = sdo;
    for (int i = 1; i < 16; i++) begin
      sclk = 1'b0; hold(4);
      f[15 - i] = sdo;
      sclk = 1'b1; hold(4);
    end
  endtask

  always @(posedge clk) begin
    wdog++;
    if (wdog > 100000) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, exp;
    hold(3);
    check(sdoEn === 1'b0 && sdo === 1'b0, "R6 reset", {sdoEn, sdo}, 0);
    rstN = 1'b1;
    hold(3);

    // R6: clock activity while deselected
    pulse(); pulse();
    check(sdoEn === 1'b0, "R6 idle clocks", sdoEn, 0);

    // external mode, channel 0, port disturbed after sampling (R1 R4 R9)
    resCode = 10'h2A5; resChan = 1'b0; resSub = 2'b10;
    exp = frameOf(1'b0, 10'h2A5, 2'b10);
    hold(2); csN = 1'b0; hold(CONV + 4);
    check(sdoEn === 1'b1 && sdo === 1'b0, "R1 external waits", {sdoEn, sdo}, 2);
    readExt(got, 1'b1);
    check(got === exp, "R9 external frame", got, exp);
    check(sdo === 1'b0, "R5 trailing zero", sdo, 0);
    pulse();
    check(sdo === 1'b0, "R5 trailing zero 2", sdo, 0);
    csN = 1'b1; hold(4);
    check(sdoEn === 1'b0, "R6 release", sdoEn, 0);

    // internal mode, channel 1, falls ignored during conversion (R3 R8)
    resCode = 10'h3FF; resChan = 1'b1; resSub = 2'b01;
    exp = frameOf(1'b1, 10'h3FF, 2'b01);
    sclk = 1'b1; hold(3);
    csN = 1'b0; hold(3);
    sclk = 1'b0; hold(4); sclk = 1'b1; hold(4);
    hold(CONV + 2 - 11);
    check(sdo === 1'b0 && sdoEn === 1'b1, "R3 converting", {sdoEn, sdo}, 2);
    hold(1);
    check(sdo === 1'b1, "R3 end of conversion", sdo, 1);
    readInt(got, 1'b1);
    check(got === exp, "R8 internal frame ch1", got, exp);
    sclk = 1'b0; hold(4);
    check(sdo === 1'b0, "R5 internal trailing", sdo, 0);
    sclk = 1'b1; csN = 1'b1; hold(4);

    // R7: abort during conversion, then fresh conversion
    resCode = 10'h155; resChan = 1'b0; resSub = 2'b11;
    csN = 1'b0; hold(10);
    csN = 1'b1; hold(4);
    check(sdoEn === 1'b0 && sdo === 1'b0, "R7 abort", {sdoEn, sdo}, 0);
    resCode = 10'h001;
    exp = frameOf(1'b0, 10'h001, 2'b11);
    csN = 1'b0; hold(CONV + 4);
    check(sdo === 1'b1, "R7 fresh eoc", sdo, 1);
    readInt(got, 1'b0);
    check(got === exp, "R7 fresh frame", got, exp);
    sclk = 1'b0; csN = 1'b1; hold(4);

    // R8 / R7: external channel 1, aborted mid-frame, then restarted
    resCode = 10'h000; resChan = 1'b1; resSub = 2'b00;
    csN = 1'b0; hold(4);
    pulse(); pulse(); pulse(); pulse();
    csN = 1'b1; hold(4);
    check(sdoEn === 1'b0, "R7 frame abort", sdoEn, 0);
    resCode = 10'h200;
    exp = frameOf(1'b1, 10'h200, 2'b00);
    csN = 1'b0; hold(4);
    readExt(got, 1'b0);
    check(got === exp, "R8 external ch1 frame", got, exp);
    csN = 1'b1; hold(6);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule